// File: doc/BRIEF.md
# Manchester Receive Decoder to Nibble Bus

This block sits behind a clock-recovery stage on a 10 Mb/s twisted-pair receiver. Each half-bit of the line comes in with a one-clock strobe (20 MHz rate, derived upstream from a 100 MHz reference divided by five) and its sampled level, together with a signal-present flag from the squelch stage. The decoder hunts for an aligned run of preamble, follows the alternating pattern until the start-of-frame pair of ones, and from then on decodes every two half-bits into one bit. It packs four bits into a nibble with the earliest bit in the least significant position.

The block presents nibbles on a 4-bit bus together with a one-clock nibble enable at one eighth of the half-bit rate (2.5 MHz), a valid flag and an error flag. The data bus carries meaning only while the valid flag is high. A frame ends on a run of zero half-bits, on the idle terminator pattern, or when signal-present drops. After that the decoder returns to hunting.

Top module: `mdec_rx`

## Requirements
- R1: After reset, `rx_vld`, `rx_err`, `nib_stb` and `rx_nib` are all low.
- R2: A bit cell whose first half-bit is 0 and second is 1 decodes as 1, and the reverse decodes as 0. The first bit decoded after the start of a frame lands in `rx_nib[0]` and the fourth in `rx_nib[3]`. A nibble is presented on the clock edge that samples the strobe carrying its eighth half-bit, with `nib_stb` high for that one clock.
- R3: Lock requires eight consecutive half-bits that form four aligned, correctly coded, alternating bits. A frame whose preamble holds fewer than four alternating bits before the pair of ones never raises `rx_vld`.
- R4: After lock, the first two consecutive 1 bits mark the start of the frame. The next four bits form the first nibble, and `rx_vld` rises only together with a `nib_stb` pulse.
- R5: While receiving a frame, a bit cell with two equal half-bits sets `rx_err` for the nibble that contains it. That bit decodes as its second half-bit, and the next clean nibble clears `rx_err`. `rx_err` is never high while `rx_vld` is low.
- R6: A code violation seen before the frame starts never produces `rx_err`. It drops the lock, and the decoder locks again on the preamble that follows.
- R7: Eight consecutive zero half-bits during a frame drop `rx_vld` at the edge that samples the eighth of them. An unfinished nibble is discarded.
- R8: The half-bit sequence 1,1,1,1,0,0,0,0 during a frame drops `rx_vld` at the edge that samples its last half-bit. A nibble completed earlier in that sequence is still delivered, with `rx_err` set.
- R9: When end-of-frame detection and nibble completion fall on the same strobe, the end wins. No nibble is delivered and `rx_vld` drops.
- R10: While `sig_ok` is low, `rx_vld` and `rx_err` are low from the next clock edge, and half-bit strobes are ignored.
- R11: With `sig_ok` high, `nib_stb` is a one-clock pulse after every eighth half-bit strobe, running whether or not a frame is in progress. It is realigned at the start of each frame.
- R12: `rx_nib` changes only on an edge where `nib_stb` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_stb | input | 1 | One-clock strobe marking a new half-bit sample |
| hb_val | input | 1 | Line level of the half-bit marked by `hb_stb` |
| sig_ok | input | 1 | Signal present from the squelch stage |
| nib_stb | output | 1 | Nibble clock enable, one clock wide |
| rx_nib | output | NIB_W | Decoded nibble, first bit in bit 0 |
| rx_vld | output | 1 | Frame data valid |
| rx_err | output | 1 | Current nibble held a code violation |

## Verification
End-of-frame detection and nibble completion can land on the same half-bit strobe. This happens when the idle terminator starts exactly on a nibble boundary: its last half-bit is also the eighth half-bit of a nibble. The bench provokes this with byte-aligned frames ending in the terminator, and expects no extra nibble and `rx_vld` low. It sets these against frames with two trailing bits, where the terminator straddles a boundary and one flagged nibble must appear before valid drops. Random frames mix both endings with the zero-run ending and with violations in random nibbles.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } mdec_state_t;

  // Eight-half-bit window, oldest half-bit in bit 7.
  localparam logic [7:0] PRE_WIN_A = 8'b0110_0110; // bits 1,0,1,0
  localparam logic [7:0] PRE_WIN_B = 8'b1001_1001; // bits 0,1,0,1
  localparam logic [7:0] IDLE_WIN  = 8'b1111_0000; // end-of-frame terminator

endpackage

// File: rtl/mdec_window.sv
module mdec_window #(
  parameter int ZERO_RUN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_ok,
  input  logic hb_stb,
  input  logic hb_val,
  output logic pre_hit,
  output logic term_hit,
  output logic zero_hit,
  output logic viol
);
  import mdec_pkg::*;

  localparam int WIN = (ZERO_RUN > 8) ? ZERO_RUN : 8;

  logic [WIN-2:0] hist;
  logic [WIN-1:0] win;

  // Window including the half-bit presented this cycle (newest in bit 0).
  assign win = {hist, hb_val};

  always_ff @(posedge clk) begin
    if (rst || !sig_ok) begin
      hist <= '0;
    end else if (hb_stb) begin
      hist <= win[WIN-2:0];
    end
  end

  assign pre_hit  = (win[7:0] == PRE_WIN_A) || (win[7:0] == PRE_WIN_B);
  assign term_hit = (win[7:0] == IDLE_WIN);
  assign zero_hit = (win[ZERO_RUN-1:0] == '0);
  assign viol     = (hist[0] == hb_val);

endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl #(
  parameter int NIB_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_ok,
  input  logic hb_stb,
  input  logic hb_val,
  input  logic pre_hit,
  input  logic term_hit,
  input  logic zero_hit,
  input  logic viol,
  output logic bit_ev,
  output logic start_ev,
  output logic end_ev,
  output logic nib_last,
  output logic nib_stb
);
  import mdec_pkg::*;

  localparam int HB_PER_NIB = 2 * NIB_W;
  localparam int HCW        = $clog2(HB_PER_NIB);
  localparam int HC_MAX     = HB_PER_NIB - 1;

  mdec_state_t    st;
  logic           ph;    // 1: current strobe is the second half of a cell
  logic           prev;  // last decoded bit while following preamble
  logic [HCW-1:0] hc;
  logic           stb;
  logic           stop;

  assign stb      = hb_stb && sig_ok;
  assign stop     = term_hit || zero_hit;
  assign nib_last = (hc == HCW'(HC_MAX));
  assign end_ev   = stb && (st == ST_DATA) && stop;
  assign bit_ev   = stb && (st == ST_DATA) && ph && !stop;
  assign start_ev = stb && (st == ST_SYNC) && ph && !viol && hb_val && prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HUNT;
      ph      <= 1'b0;
      prev    <= 1'b0;
      hc      <= '0;
      nib_stb <= 1'b0;
    end else begin
      nib_stb <= stb && nib_last;
      if (!sig_ok) begin
        st <= ST_HUNT;
        ph <= 1'b0;
      end else if (hb_stb) begin
        ph <= ~ph;
        hc <= nib_last ? '0 : hc + 1'b1;
        unique case (st)
          ST_HUNT: begin
            if (pre_hit) begin
              st   <= ST_SYNC;
              ph   <= 1'b0;
              prev <= hb_val;
            end
          end
          ST_SYNC: begin
            if (ph) begin
              prev <= hb_val;
              if (viol) begin
                st <= ST_HUNT;
              end else if (hb_val == prev) begin
                if (hb_val) begin
                  st <= ST_DATA;
                  hc <= '0;
                end else begin
                  st <= ST_HUNT;
                end
              end
            end
          end
          ST_DATA: begin
            if (stop) st <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdec_pack.sv
module mdec_pack #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_ok,
  input  logic             bit_ev,
  input  logic             start_ev,
  input  logic             end_ev,
  input  logic             nib_last,
  input  logic             dbit,
  input  logic             viol,
  output logic [NIB_W-1:0] rx_nib,
  output logic             rx_vld,
  output logic             rx_err
);

  logic [NIB_W-1:0] sh;
  logic [NIB_W-1:0] nxt;
  logic             pend;

  // Shift in from the top so the earliest bit ends in bit 0.
  assign nxt = {dbit, sh[NIB_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      pend   <= 1'b0;
      rx_nib <= '0;
      rx_vld <= 1'b0;
      rx_err <= 1'b0;
    end else if (!sig_ok || end_ev) begin
      pend   <= 1'b0;
      rx_vld <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      if (start_ev) pend <= 1'b0;
      if (bit_ev) begin
        sh <= nxt;
        if (nib_last) begin
          rx_nib <= nxt;
          rx_vld <= 1'b1;
          rx_err <= pend | viol;
          pend   <= 1'b0;
        end else begin
          pend <= pend | viol;
        end
      end
    end
  end

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx #(
  parameter int NIB_W    = 4,
  parameter int ZERO_RUN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hb_stb,
  input  logic             hb_val,
  input  logic             sig_ok,
  output logic             nib_stb,
  output logic [NIB_W-1:0] rx_nib,
  output logic             rx_vld,
  output logic             rx_err
);

  logic pre_hit, term_hit, zero_hit, viol;
  logic bit_ev, start_ev, end_ev, nib_last;

  mdec_window #(.ZERO_RUN(ZERO_RUN)) u_win (
    .clk      (clk),
    .rst      (rst),
    .sig_ok   (sig_ok),
    .hb_stb   (hb_stb),
    .hb_val   (hb_val),
    .pre_hit  (pre_hit),
    .term_hit (term_hit),
    .zero_hit (zero_hit),
    .viol     (viol)
  );

  mdec_ctrl #(.NIB_W(NIB_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sig_ok   (sig_ok),
    .hb_stb   (hb_stb),
    .hb_val   (hb_val),
    .pre_hit  (pre_hit),
    .term_hit (term_hit),
    .zero_hit (zero_hit),
    .viol     (viol),
    .bit_ev   (bit_ev),
    .start_ev (start_ev),
    .end_ev   (end_ev),
    .nib_last (nib_last),
    .nib_stb  (nib_stb)
  );

  mdec_pack #(.NIB_W(NIB_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .sig_ok   (sig_ok),
    .bit_ev   (bit_ev),
    .start_ev (start_ev),
    .end_ev   (end_ev),
    .nib_last (nib_last),
    .dbit     (hb_val),
    .viol     (viol),
    .rx_nib   (rx_nib),
    .rx_vld   (rx_vld),
    .rx_err   (rx_err)
  );

endmodule

// File: rtl/mdec_rx_chk.sv
module mdec_rx_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hb_stb,
  input logic             sig_ok,
  input logic             nib_stb,
  input logic [NIB_W-1:0] rx_nib,
  input logic             rx_vld,
  input logic             rx_err
);

  a_r5_err_needs_vld: assert property (@(posedge clk) disable iff (rst)
    rx_err |-> rx_vld);

  a_r4_vld_rises_on_stb: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_vld) |-> nib_stb);

  a_r10_sig_loss: assert property (@(posedge clk) disable iff (rst)
    !sig_ok |=> (!rx_vld && !rx_err));

  a_r11_stb_one_clk: assert property (@(posedge clk) disable iff (rst)
    nib_stb |=> !nib_stb);

  a_r11_stb_follows_hb: assert property (@(posedge clk) disable iff (rst)
    nib_stb |-> $past(hb_stb && sig_ok));

  a_r12_nib_moves_on_stb: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_nib) |-> nib_stb);

endmodule

bind mdec_rx mdec_rx_chk #(.NIB_W(NIB_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hb_stb  (hb_stb),
  .sig_ok  (sig_ok),
  .nib_stb (nib_stb),
  .rx_nib  (rx_nib),
  .rx_vld  (rx_vld),
  .rx_err  (rx_err)
);

// File: tb/tb_mdec_rx.sv
`timescale 1ns/1ps
module tb_mdec_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hb_stb = 1'b0;
  logic       hb_val = 1'b0;
  logic       sig_ok = 1'b1;
  logic       nib_stb;
  logic [3:0] rx_nib;
  logic       rx_vld;
  logic       rx_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [3:0] tx    [64];
  logic [3:0] exp_n [64];
  logic       exp_e [64];
  int         exp_cnt;
  logic [3:0] got_n [64];
  logic       got_e [64];
  int         got_cnt  = 0;
  int         vld_seen = 0;
  int         stb_cnt  = 0;
  int         gap_max  = 2;

  always #2.5 clk = ~clk;

  mdec_rx dut (
    .clk(clk), .rst(rst), .hb_stb(hb_stb), .hb_val(hb_val), .sig_ok(sig_ok),
    .nib_stb(nib_stb), .rx_nib(rx_nib), .rx_vld(rx_vld), .rx_err(rx_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (nib_stb) stb_cnt++;
      if (rx_vld) vld_seen++;
      if (nib_stb && rx_vld && got_cnt < 64) begin
        got_n[got_cnt] = rx_nib;
        got_e[got_cnt] = rx_err;
        got_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hb(input bit v);
    @(negedge clk);
    hb_val = v;
    hb_stb = 1'b1;
    @(negedge clk);
    hb_stb = 1'b0;
    repeat ($urandom_range(0, gap_max)) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    hb(~b);
    hb(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) hb(1'b0);
  endtask

  function automatic logic [3:0] with_bit(input logic [3:0] v, input int pos);
    logic [3:0] r;
    r = v;
    r[pos] = 1'b1;
    return r;
  endfunction

  // pre: even count of alternating preamble bits; pviol: preamble bit replaced by a
  // violation; endk 0 = idle terminator, 1 = zero run; extra: 2 trailing bits.
  task automatic frame(input int pre, input int pviol, input int nn, input int err_nib,
                       input int err_bit, input int endk, input bit extra,
                       input bit xb0, input bit xb1);
    got_cnt = 0;
    exp_cnt = 0;
    for (int i = 0; i < pre; i++) begin
      if (i == pviol) begin hb(1'b1); hb(1'b1); end
      else send_bit((i % 2) == 0);
    end
    send_bit(1'b1);
    send_bit(1'b1);
    for (int k = 0; k < nn; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (k == err_nib && j == err_bit) begin hb(1'b1); hb(1'b1); end
        else send_bit(tx[k][j]);
      end
      exp_n[exp_cnt] = (k == err_nib) ? with_bit(tx[k], err_bit) : tx[k];
      exp_e[exp_cnt] = (k == err_nib);
      exp_cnt++;
    end
    if (extra) begin
      send_bit(xb0);
      send_bit(xb1);
      exp_n[exp_cnt] = (endk == 0) ? {2'b11, xb1, xb0} : {2'b00, xb1, xb0};
      exp_e[exp_cnt] = 1'b1;
      exp_cnt++;
    end
    if (endk == 0) begin
      hb(1'b1); hb(1'b1); hb(1'b1); hb(1'b1);
      hb(1'b0); hb(1'b0); hb(1'b0); hb(1'b0);
    end else begin
      idle(8);
    end
  endtask

  task automatic compare(input string req);
    check(got_cnt == exp_cnt, {req, " nibble count"}, got_cnt, exp_cnt);
    for (int k = 0; k < exp_cnt && k < got_cnt; k++) begin
      check(got_n[k] == exp_n[k], {req, " nibble value"}, got_n[k], exp_n[k]);
      check(got_e[k] == exp_e[k], {req, " error flag"}, got_e[k], exp_e[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B_3C4D));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rx_vld == 0 && rx_err == 0 && nib_stb == 0 && rx_nib == 0, "R1 reset outputs",
          {rx_vld, rx_err, nib_stb, rx_nib}, 0);

    // R11: free-running nibble enable, 80 strobes -> 10 pulses
    idle(4);
    repeat (2) @(negedge clk);
    stb_cnt = 0;
    idle(80);
    repeat (2) @(negedge clk);
    check(stb_cnt == 10, "R11 nib_stb rate", stb_cnt, 10);

    // R2/R4/R3: minimal 4-bit preamble, bit order, aligned terminator (R8, R9)
    tx[0] = 4'h1; tx[1] = 4'h8; tx[2] = 4'hA; tx[3] = 4'h5;
    frame(4, -1, 4, -1, 0, 0, 1'b0, 1'b0, 1'b0);
    check(rx_vld == 0, "R8 vld low after terminator", rx_vld, 0);
    compare("R2 R4 R9 aligned frame");
    idle(6);

    // R3: too-short preamble never locks
    vld_seen = 0;
    tx[0] = 4'hF; tx[1] = 4'hF; tx[2] = 4'hF;
    frame(2, -1, 3, -1, 0, 0, 1'b0, 1'b0, 1'b0);
    idle(6);
    check(vld_seen == 0, "R3 short preamble", vld_seen, 0);

    // R5: violation in a middle nibble; R7: zero-run ending
    tx[0] = 4'h3; tx[1] = 4'h0; tx[2] = 4'hC; tx[3] = 4'h6;
    frame(10, -1, 4, 1, 2, 1, 1'b0, 1'b0, 1'b0);
    check(rx_vld == 0, "R7 vld low after zero run", rx_vld, 0);
    compare("R5 R7 violation frame");
    idle(6);

    // R6: violation inside the preamble, relock, no error
    tx[0] = 4'h9; tx[1] = 4'h7;
    frame(20, 6, 2, -1, 0, 0, 1'b0, 1'b0, 1'b0);
    compare("R6 preamble violation");
    idle(6);

    // R8: terminator straddling a nibble boundary
    tx[0] = 4'hE; tx[1] = 4'h2;
    frame(8, -1, 2, -1, 0, 0, 1'b1, 1'b1, 1'b0);
    check(rx_vld == 0, "R8 vld low after straddled terminator", rx_vld, 0);
    compare("R8 straddled terminator");
    idle(6);

    // R10: signal loss mid-frame
    got_cnt = 0;
    tx[0] = 4'h4; tx[1] = 4'hB;
    for (int i = 0; i < 8; i++) send_bit((i % 2) == 0);
    send_bit(1'b1); send_bit(1'b1);
    for (int k = 0; k < 2; k++) for (int j = 0; j < 4; j++) send_bit(tx[k][j]);
    send_bit(1'b1); send_bit(1'b0);
    check(rx_vld == 1, "R10 vld before loss", rx_vld, 1);
    @(negedge clk);
    sig_ok = 1'b0;
    @(negedge clk);
    check(rx_vld == 0 && rx_err == 0, "R10 vld low after loss", {rx_vld, rx_err}, 0);
    for (int i = 0; i < 12; i++) send_bit(i % 3 == 0);
    check(got_cnt == 2 && rx_vld == 0, "R10 strobes ignored", got_cnt, 2);
    sig_ok = 1'b1;
    idle(4);
    tx[0] = 4'hD;
    frame(6, -1, 1, -1, 0, 0, 1'b0, 1'b0, 1'b0);
    compare("R10 recovery frame");
    idle(6);

    // Random frames: R2 R5 R7 R8 R9
    for (int f = 0; f < 25; f++) begin
      int nn, pre, en, eb, endk;
      bit ex;
      gap_max = $urandom_range(0, 3);
      nn   = $urandom_range(1, 12);
      pre  = 2 * $urandom_range(2, 12);
      en   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, nn - 1) : -1;
      eb   = $urandom_range(0, 3);
      endk = $urandom_range(0, 1);
      ex   = $urandom_range(0, 1);
      for (int k = 0; k < nn; k++) tx[k] = 4'($urandom_range(0, 15));
      frame(pre, -1, nn, en, eb, endk, ex, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      check(rx_vld == 0, "R7 R8 random end", rx_vld, 0);
      compare("R2 R5 random frame");
      idle($urandom_range(2, 10));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule